// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word. It has two register ranks. Each accepted serial beat moves the bits of the shift rank up by one stage. A separate store strobe copies the whole shift rank into a holding rank. The holding rank drives the parallel output, so the parallel word changes only when a store is requested, and never while bits are still being shifted in. The last shift stage is also available as a serial output. Feeding it into the serial input of a second instance makes a longer chain.

Both ranks run on one core clock. The serial input is a valid/ready stream. A beat is accepted in any cycle where both `ser_valid` and `ser_ready` are high. `ser_ready` is low only while the clear input is asserted, so the stream is held back only during a clear. The store strobe, the clear and the output enable are plain control pins. The clear is asynchronous and active low, and it acts on the shift rank only. The output enable is active low. The tri-state parallel bus is modelled as a data word plus a drive flag: while the bus is released, the flag is low and the data reads as zero.

Top module: `stp_latched_s2p`

## Requirements
- R1: An accepted beat (`ser_valid` and `ser_ready` both high at a rising clock edge) loads `ser_data` into stage 0 and moves stage n into stage n+1. After a store, bit k of `par_data` equals stage k.
- R2: In a cycle with no accepted beat, every shift stage keeps its value.
- R3: `ser_ready` is high while `clr_n` is high and low while `clr_n` is low. There is no other back-pressure.
- R4: A clock edge with `store_stb` high copies the shift rank into the holding rank. Without a store, the holding rank and `par_data` stay unchanged, even while beats are shifted in.
- R5: When a store and an accepted beat fall on the same edge, the holding rank takes the shift contents from before that beat.
- R6: `ser_out` always equals the last shift stage (stage 7 at the default width), so it presents bits in the order they entered, one width later.
- R7: `clr_n` low clears all shift stages at once, without waiting for a clock edge, and leaves the holding rank unchanged. A store made after a clear loads zeros.
- R8: With `oe_n` low, `par_en` is 1 and `par_data` shows the holding rank. With `oe_n` high, `par_en` is 0 and `par_data` is all zeros.
- R9: When two instances are chained (`ser_out` of the first into `ser_data` of the second), sixteen beats followed by one store leave the last eight bits entered on the first instance's parallel bus and the first eight on the second's. The most recent bit appears at bit 0 of the first instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for both register ranks |
| clr_n | input | 1 | Asynchronous active-low clear of the shift rank |
| ser_valid | input | 1 | Serial beat valid |
| ser_ready | output | 1 | Serial beat ready (low during clear) |
| ser_data | input | 1 | Serial data bit |
| store_stb | input | 1 | Copy the shift rank into the holding rank |
| oe_n | input | 1 | Active-low parallel output enable |
| ser_out | output | 1 | Last shift stage, for chaining |
| par_en | output | 1 | Parallel bus driven flag |
| par_data | output | STAGES | Parallel word (zero when not driven) |

## Verification
A serial beat and a store strobe can be accepted on the same clock edge. Here the holding rank must capture the word from before the shift, not the one after it. The bench loads a known word, then raises `store_stb` together with a beat carrying the complement of the bit that would enter. It then compares the parallel bus with the pre-shift word, and the serial output with the post-shift stage 7. A second collision, a clear held across a store edge, is judged by checking that the holding rank then reads all zeros.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int unsigned STP_STAGES_DEFAULT = 8;

  function automatic logic stp_beat(input logic valid, input logic ready);
    return valid & ready;
  endfunction
endpackage

// File: rtl/stp_shift_rank.sv
module stp_shift_rank #(
  parameter int unsigned STAGES = stp_pkg::STP_STAGES_DEFAULT
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              step,
  input  logic              din,
  output logic [STAGES-1:0] stages
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)    stages[g] <= 1'b0;
        else if (step) stages[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)    stages[g] <= 1'b0;
        else if (step) stages[g] <= stages[g-1];
      end
    end
  end

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
    step |=> (stages == {$past(stages[LAST-1:0]), $past(din)}));

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !step |=> $stable(stages));

  // R7
  shift_clear_chk: assert property (@(posedge clk)
    !clr_n |-> (stages == '0));
endmodule

// File: rtl/stp_hold_rank.sv
module stp_hold_rank #(
  parameter int unsigned STAGES = stp_pkg::STP_STAGES_DEFAULT
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              store,
  input  logic [STAGES-1:0] src,
  output logic [STAGES-1:0] held
);
  always_ff @(posedge clk) begin
    if (store) held <= src;
  end

  // R4, R5: captured value is the source seen before the edge
  hold_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    store |=> (held == $past(src)));

  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !store |=> $stable(held));
endmodule

// File: rtl/stp_out_drive.sv
module stp_out_drive #(
  parameter int unsigned STAGES = stp_pkg::STP_STAGES_DEFAULT
) (
  input  logic              oe_n,
  input  logic [STAGES-1:0] held,
  output logic              bus_en,
  output logic [STAGES-1:0] bus_data
);
  always_comb begin
    bus_en   = ~oe_n;
    bus_data = oe_n ? '0 : held;
  end
endmodule

// File: rtl/stp_latched_s2p.sv
module stp_latched_s2p #(
  parameter int unsigned STAGES = stp_pkg::STP_STAGES_DEFAULT
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ser_valid,
  output logic              ser_ready,
  input  logic              ser_data,
  input  logic              store_stb,
  input  logic              oe_n,
  output logic              ser_out,
  output logic              par_en,
  output logic [STAGES-1:0] par_data
);
  localparam int unsigned LAST = STAGES - 1;

  logic              beat;
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] hold_q;

  assign ser_ready = clr_n;
  assign beat      = stp_pkg::stp_beat(ser_valid, ser_ready);
  assign ser_out   = shift_q[LAST];

  stp_shift_rank #(.STAGES(STAGES)) u_shift (
    .clk    (clk),
    .clr_n  (clr_n),
    .step   (beat),
    .din    (ser_data),
    .stages (shift_q)
  );

  stp_hold_rank #(.STAGES(STAGES)) u_hold (
    .clk   (clk),
    .clr_n (clr_n),
    .store (store_stb),
    .src   (shift_q),
    .held  (hold_q)
  );

  stp_out_drive #(.STAGES(STAGES)) u_drive (
    .oe_n     (oe_n),
    .held     (hold_q),
    .bus_en   (par_en),
    .bus_data (par_data)
  );

  // R8
  out_show_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !oe_n |-> (par_en && par_data == hold_q));

  // R8
  out_float_chk: assert property (@(posedge clk) disable iff (!clr_n)
    oe_n |-> (!par_en && par_data == '0));

  // R6
  out_serial_chk: assert property (@(posedge clk) disable iff (!clr_n)
    beat |=> (ser_out == $past(shift_q[LAST-1])));
endmodule

// File: tb/test_stp_latched_s2p.sv
module test_stp_latched_s2p;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         clr_n, valid, din, store, oe_n;
  logic         rdy_a, rdy_b, so_a, so_b, en_a, en_b;
  logic [W-1:0] pd_a, pd_b;

  stp_latched_s2p #(.STAGES(W)) i_stp_latched_s2p (
    .clk(clk), .clr_n(clr_n), .ser_valid(valid), .ser_ready(rdy_a),
    .ser_data(din), .store_stb(store), .oe_n(oe_n), .ser_out(so_a),
    .par_en(en_a), .par_data(pd_a)
  );

  stp_latched_s2p #(.STAGES(W)) i_stp_latched_s2p_b (
    .clk(clk), .clr_n(clr_n), .ser_valid(valid), .ser_ready(rdy_b),
    .ser_data(so_a), .store_stb(store), .oe_n(oe_n), .ser_out(so_b),
    .par_en(en_b), .par_data(pd_b)
  );

  int checks = 0;
  int errors = 0;
  logic [2*W-1:0] chain_m;
  logic [W-1:0]   hold_m;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic b, input logic st);
    valid = 1'b1; din = b; store = st;
    if (st) hold_m = chain_m[W-1:0];
    chain_m = {chain_m[2*W-2:0], b};
    @(negedge clk);
    valid = 1'b0; store = 1'b0;
  endtask

  task automatic do_store();
    store = 1'b1; hold_m = chain_m[W-1:0];
    @(negedge clk);
    store = 1'b0;
  endtask

  task automatic load_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) beat(w[i], 1'b0);
  endtask

  task automatic t_reset();
    clr_n = 1'b0; valid = 1'b0; din = 1'b0; store = 1'b0; oe_n = 1'b0;
    chain_m = '0;
    repeat (2) @(negedge clk);
    check("R3 ready low in clear", rdy_a, 0);
    check("R7 ser_out zero in clear", so_a, 0);
    do_store();
    check("R7 store in clear loads zeros", pd_a, 0);
    clr_n = 1'b1;
    @(negedge clk);
    check("R3 ready high", rdy_a, 1);
  endtask

  task automatic t_shift_store();
    load_word(8'hA5);
    check("R6 ser_out first bit", so_a, 1);
    do_store();
    check("R1 word A5", pd_a, 8'hA5);
    load_word(8'h3C);
    check("R4 no store keeps bus", pd_a, 8'hA5);
    do_store();
    check("R1 word 3C", pd_a, 8'h3C);
  endtask

  task automatic t_idle();
    din = 1'b1;
    repeat (3) @(negedge clk);
    do_store();
    check("R2 idle keeps stages", pd_a, 8'h3C);
  endtask

  task automatic t_coincident();
    load_word(8'h81);
    beat(1'b0, 1'b1);
    check("R5 store takes pre-shift", pd_a, 8'h81);
    check("R6 ser_out after shift", so_a, 0);
    do_store();
    check("R5 next store sees shifted", pd_a, 8'h02);
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    #1;
    check("R8 released flag", en_a, 0);
    check("R8 released data", pd_a, 0);
    oe_n = 1'b0;
    #1;
    check("R8 driven flag", en_a, 1);
    check("R8 driven data", pd_a, hold_m);
    @(negedge clk);
  endtask

  task automatic t_clear();
    load_word(8'hFF);
    do_store();
    clr_n = 1'b0;
    #1;
    check("R7 async clear ser_out", so_a, 0);
    check("R3 ready drops", rdy_a, 0);
    @(negedge clk);
    clr_n = 1'b1;
    chain_m = '0;
    check("R7 clear keeps hold", pd_a, 8'hFF);
    @(negedge clk);
    do_store();
    check("R7 store after clear zeros", pd_a, 0);
  endtask

  task automatic t_chain();
    logic [2*W-1:0] pat = 16'hC39A;
    for (int i = 2 * W - 1; i >= 0; i--) beat(pat[i], 1'b0);
    do_store();
    check("R9 first instance low byte", pd_a, pat[W-1:0]);
    check("R9 second instance high byte", pd_b, pat[2*W-1:W]);
    check("R9 model agrees", {pd_b, pd_a}, chain_m);
    check("R6 chain ser_out", so_b, pat[2*W-1]);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_shift_store();
        t_idle();
        t_coincident();
        t_oe();
        t_clear();
        t_chain();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule